// File: doc/BRIEF.md
# SPI Command Request Receiver

This block sits on the peripheral side of a SPI link and collects one host command request per chip-select window. A falling chip select opens a transaction. Each byte shifted in on MOSI (SPI mode 0, MSB first) is stored in order in a request buffer, starting at address 0. The first byte selects the request flavour. A value equal to the packet protocol code marks a packet request. The header of such a request has a fixed length and carries a 16-bit body length. A value at or above the legacy base marks a legacy request, whose third byte is the parameter count. From this the block works out the total size, waits for exactly that many bytes, and then raises a one-cycle request strobe together with the length and the flavour.

The downstream consumer reads the stored bytes through a combinational read port while the request is held. It releases the buffer with an acknowledge pulse. Any failure abandons the transaction and waits for a fresh chip-select fall. The failures are: chip select released early, a wait phase that runs past its time budget, an unknown first byte, or a size the buffer cannot hold. Throughout, the MISO line repeats the stall byte so the host sees that no answer is ready.

Top module: `spireq_rx`

## Requirements
- R1: After reset the block is idle: `req_valid` is 0 and `spi_miso` is 1, the MSB of the stall byte 0xFD.
- R2: A first byte at or above LEGACY_BASE (0xDC) marks a legacy request. Its total size is 3 plus the third byte. When that many bytes have arrived, `req_len` reports the size, `req_pkt` is 0, and buffer address i holds received byte i.
- R3: A first byte equal to PKT_VER (0x03) marks a packet request. Its total size is HDR_BYTES (8) plus a 16-bit little-endian length taken from header byte 6 (low) and byte 7 (high). On completion `req_pkt` is 1 and `req_len` reports that total.
- R4: A computed size of zero or above BUF_BYTES (544) abandons the transaction with no strobe. A size of exactly 544 is accepted.
- R5: A first byte that is neither PKT_VER nor at or above LEGACY_BASE abandons the transaction with no strobe.
- R6: If chip select rises before the expected byte count has arrived, the transaction is abandoned with no strobe.
- R7: Each wait phase (the first three bytes, the rest of the packet header, the body) has a budget of TIMEOUT_US times CLKS_PER_US clock cycles, counted from the start of that phase. When the budget runs out, the transaction is abandoned. Bytes that follow are ignored until a new chip-select fall.
- R8: SCLK activity while chip select is high is ignored. Bit alignment restarts at every chip-select fall.
- R9: `req_valid` is high for exactly one cycle per completed request. Until `req_ack`, `req_len`, `req_pkt` and the buffer stay frozen, and SPI traffic starts no new request.
- R10: While chip select is low, MISO sends the stall byte 0xFD over and over, MSB first. It changes after SCLK falling edges and is stable at rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host (stall pattern) |
| req_valid | output | 1 | One-cycle strobe: a complete request is held |
| req_len | output | 10 | Total request size in bytes |
| req_pkt | output | 1 | 1 for a packet request, 0 for a legacy request |
| req_ack | input | 1 | Consumer releases the held request |
| rd_addr | input | 10 | Buffer read address |
| rd_data | output | 8 | Buffer byte at `rd_addr` |

## Verification
The bound checker watches every cycle for several things. The strobe lasts one cycle and never repeats while a request is held. The length and read data stay frozen until the acknowledge. Every reported size lies within the buffer. A chip-select release or an expired phase budget always drops the receiver out of its receiving states without a strobe. Only the bench scenarios can show the rest: the size decoding for both request flavours, the stored byte order, the rejection of unknown codes and oversize headers, the exact 544-byte limit, the MISO stall pattern, and the need for a fresh chip-select fall after an abort.

// File: rtl/spireq_pkg.sv
package spireq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HEAD = 3'd1,
    ST_PHDR = 3'd2,
    ST_BODY = 3'd3,
    ST_HOLD = 3'd4
  } rx_state_e;

  localparam int unsigned SIZE_W = 17;
endpackage

// File: rtl/spireq_front.sv
module spireq_front #(
  parameter logic [7:0] STALL = 8'hFD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       cs_fall,
  output logic       cs_high,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       miso
);
  logic [1:0] sclk_sy, cs_sy, mosi_sy;
  logic       sclk_p, cs_p;
  logic [2:0] bit_q, bit_d;
  logic [6:0] rsh_q, rsh_d;
  logic       stb_q, stb_d;
  logic [7:0] byte_q, byte_d;
  logic [7:0] tsh_q, tsh_d;
  logic [2:0] tcnt_q, tcnt_d;
  logic       rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= 2'b00;
      cs_sy   <= 2'b11;
      mosi_sy <= 2'b00;
      sclk_p  <= 1'b0;
      cs_p    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk};
      cs_sy   <= {cs_sy[0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
      sclk_p  <= sclk_sy[1];
      cs_p    <= cs_sy[1];
    end
  end

  assign rise    = sclk_sy[1] & ~sclk_p;
  assign fall    = ~sclk_sy[1] & sclk_p;
  assign cs_high = cs_sy[1];
  assign cs_fall = cs_p & ~cs_sy[1];

  always_comb begin
    bit_d  = bit_q;
    rsh_d  = rsh_q;
    stb_d  = 1'b0;
    byte_d = byte_q;
    tsh_d  = tsh_q;
    tcnt_d = tcnt_q;
    if (cs_high) begin
      bit_d  = '0;
      tsh_d  = STALL;
      tcnt_d = '0;
    end else begin
      if (rise) begin
        rsh_d = {rsh_q[5:0], mosi_sy[1]};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          stb_d  = 1'b1;
          byte_d = {rsh_q, mosi_sy[1]};
        end
      end
      if (fall) begin
        tcnt_d = tcnt_q + 3'd1;
        tsh_d  = (tcnt_q == 3'd7) ? STALL : {tsh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rsh_q  <= '0;
      stb_q  <= 1'b0;
      byte_q <= '0;
      tsh_q  <= STALL;
      tcnt_q <= '0;
    end else begin
      bit_q  <= bit_d;
      rsh_q  <= rsh_d;
      stb_q  <= stb_d;
      byte_q <= byte_d;
      tsh_q  <= tsh_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign byte_stb  = stb_q;
  assign byte_data = byte_q;
  assign miso      = tsh_q[7];
endmodule

// File: rtl/spireq_sizer.sv
module spireq_sizer
  import spireq_pkg::*;
#(
  parameter int unsigned HDR_BYTES   = 8,
  parameter int unsigned LEN_OFS     = 6,
  parameter logic [7:0]  PKT_VER     = 8'h03,
  parameter logic [7:0]  LEGACY_BASE = 8'hDC,
  parameter int unsigned BUF_BYTES   = 544
) (
  input  logic [HDR_BYTES-1:0][7:0] hdr,
  output logic                      is_pkt,
  output logic                      is_legacy,
  output logic [SIZE_W-1:0]         legacy_total,
  output logic                      legacy_ok,
  output logic [SIZE_W-1:0]         pkt_total,
  output logic                      pkt_ok
);
  logic [15:0] body_len;

  assign is_pkt       = (hdr[0] == PKT_VER);
  assign is_legacy    = (hdr[0] >= LEGACY_BASE);
  assign legacy_total = SIZE_W'(3) + SIZE_W'(hdr[2]);
  assign legacy_ok    = (legacy_total != '0) && (legacy_total <= SIZE_W'(BUF_BYTES));
  assign body_len     = {hdr[LEN_OFS+1], hdr[LEN_OFS]};
  assign pkt_total    = SIZE_W'(HDR_BYTES) + SIZE_W'(body_len);
  assign pkt_ok       = (pkt_total != '0) && (pkt_total <= SIZE_W'(BUF_BYTES));
endmodule

// File: rtl/spireq_timer.sv
module spireq_timer #(
  parameter int unsigned LIMIT = 2048000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (!expired)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spireq_rx.sv
module spireq_rx
  import spireq_pkg::*;
#(
  parameter logic [7:0]  PKT_VER     = 8'h03,
  parameter logic [7:0]  LEGACY_BASE = 8'hDC,
  parameter int unsigned HDR_BYTES   = 8,
  parameter int unsigned LEN_OFS     = 6,
  parameter int unsigned BUF_BYTES   = 544,
  parameter int unsigned CLKS_PER_US = 250,
  parameter int unsigned TIMEOUT_US  = 8192,
  parameter logic [7:0]  STALL       = 8'hFD,
  localparam int unsigned AW    = $clog2(BUF_BYTES),
  localparam int unsigned LW    = $clog2(BUF_BYTES + 1),
  localparam int unsigned LIMIT = CLKS_PER_US * TIMEOUT_US
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          req_valid,
  output logic [LW-1:0] req_len,
  output logic          req_pkt,
  input  logic          req_ack,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic        cs_fall, cs_high, byte_stb;
  logic [7:0]  byte_data;
  logic        tmr_exp, tmr_restart, rx_active;

  rx_state_e   st_q, st_d;
  logic [LW-1:0] ptr_q, ptr_d, cnt_nx, exp_q, exp_d, len_q, len_d;
  logic        kind_q, kind_d, valid_q, valid_d, wr_en, finish;

  logic [HDR_BYTES-1:0][7:0] hdr_q, hdr_v;
  logic        is_pkt, is_legacy, legacy_ok, pkt_ok;
  logic [SIZE_W-1:0] legacy_total, pkt_total;

  logic [7:0]  mem [BUF_BYTES];

  spireq_front #(.STALL(STALL)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .cs_fall(cs_fall), .cs_high(cs_high), .byte_stb(byte_stb),
    .byte_data(byte_data), .miso(spi_miso)
  );

  spireq_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(rx_active), .restart(tmr_restart), .expired(tmr_exp)
  );

  assign rx_active = (st_q == ST_HEAD) || (st_q == ST_PHDR) || (st_q == ST_BODY);

  // header view including the byte arriving this cycle
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hdr_v[g] = (byte_stb && rx_active && (ptr_q == LW'(g))) ? byte_data : hdr_q[g];
  end

  spireq_sizer #(
    .HDR_BYTES(HDR_BYTES), .LEN_OFS(LEN_OFS), .PKT_VER(PKT_VER),
    .LEGACY_BASE(LEGACY_BASE), .BUF_BYTES(BUF_BYTES)
  ) u_sizer (
    .hdr(hdr_v), .is_pkt(is_pkt), .is_legacy(is_legacy),
    .legacy_total(legacy_total), .legacy_ok(legacy_ok),
    .pkt_total(pkt_total), .pkt_ok(pkt_ok)
  );

  always_comb begin
    st_d        = st_q;
    ptr_d       = ptr_q;
    exp_d       = exp_q;
    kind_d      = kind_q;
    len_d       = len_q;
    valid_d     = 1'b0;
    wr_en       = 1'b0;
    tmr_restart = 1'b0;
    finish      = 1'b0;
    cnt_nx      = ptr_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (cs_fall) begin
          st_d        = ST_HEAD;
          ptr_d       = '0;
          tmr_restart = 1'b1;
        end
      end
      ST_HEAD, ST_PHDR, ST_BODY: begin
        if (cs_high || tmr_exp) begin
          st_d = ST_IDLE;
        end else if (byte_stb) begin
          wr_en = 1'b1;
          ptr_d = cnt_nx;
          if (st_q == ST_HEAD && cnt_nx == LW'(3)) begin
            if (is_pkt) begin
              st_d        = ST_PHDR;
              kind_d      = 1'b1;
              tmr_restart = 1'b1;
            end else if (is_legacy && legacy_ok) begin
              kind_d      = 1'b0;
              exp_d       = legacy_total[LW-1:0];
              tmr_restart = 1'b1;
              if (legacy_total == SIZE_W'(3)) finish = 1'b1;
              else                            st_d   = ST_BODY;
            end else begin
              st_d = ST_IDLE;
            end
          end else if (st_q == ST_PHDR && cnt_nx == LW'(HDR_BYTES)) begin
            if (!pkt_ok) begin
              st_d = ST_IDLE;
            end else begin
              exp_d       = pkt_total[LW-1:0];
              tmr_restart = 1'b1;
              if (pkt_total == SIZE_W'(HDR_BYTES)) finish = 1'b1;
              else                                 st_d   = ST_BODY;
            end
          end else if (st_q == ST_BODY && cnt_nx == exp_q) begin
            finish = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (req_ack) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (finish) begin
      st_d    = ST_HOLD;
      valid_d = 1'b1;
      len_d   = cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      exp_q   <= '0;
      kind_q  <= 1'b0;
      len_q   <= '0;
      valid_q <= 1'b0;
      hdr_q   <= '0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      exp_q   <= exp_d;
      kind_q  <= kind_d;
      len_q   <= len_d;
      valid_q <= valid_d;
      if (wr_en) hdr_q <= hdr_v;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr_q[AW-1:0]] <= byte_data;
  end

  assign rd_data   = (rd_addr < AW'(BUF_BYTES)) ? mem[rd_addr] : 8'h00;
  assign req_valid = valid_q;
  assign req_len   = len_q;
  assign req_pkt   = kind_q;
endmodule

// File: rtl/spireq_rx_chk.sv
module spireq_rx_chk #(
  parameter int unsigned BUF_BYTES = 544,
  parameter int unsigned AW = 10,
  parameter int unsigned LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [LW-1:0] req_len,
  input logic          req_ack,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          rx_active,
  input logic          cs_high,
  input logic          tmr_exp
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= 1'b0;
    else if (req_valid) held <= 1'b1;
    else if (req_ack)   held <= 1'b0;
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_no_revalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !req_valid);

  assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !req_ack) |=> $stable(req_len));

  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !req_ack) |=> (!$stable(rd_addr) || $stable(rd_data)));

  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len >= LW'(3) && req_len <= LW'(BUF_BYTES)));

  assert_cs_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && cs_high) |=> (!rx_active && !req_valid));

  assert_timeout_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && tmr_exp) |=> (!rx_active && !req_valid));

  assert_no_start_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_active && cs_high) |=> !rx_active);
endmodule

bind spireq_rx spireq_rx_chk #(.BUF_BYTES(BUF_BYTES), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
  .req_ack(req_ack), .rd_addr(rd_addr), .rd_data(rd_data),
  .rx_active(rx_active), .cs_high(cs_high), .tmr_exp(tmr_exp)
);

// File: tb/spireq_rx_tb.sv
`timescale 1ns/1ps
module spireq_rx_tb;
  localparam int unsigned TO_CYC = 15000 * 4;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, req_ack = 1'b0;
  logic [9:0] rd_addr = '0;
  logic miso, req_valid, req_pkt;
  logic [9:0] req_len;
  logic [7:0] rd_data;

  int total = 0, bad = 0, vcnt = 0, miso_err = 0;
  logic [9:0] last_len;
  logic last_pkt;
  bit finished = 0;

  always #2 clk = ~clk;

  spireq_rx #(.CLKS_PER_US(4), .TIMEOUT_US(15000)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .req_valid(req_valid), .req_len(req_len), .req_pkt(req_pkt),
    .req_ack(req_ack), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (rst_n && req_valid) begin
    vcnt++;
    last_len = req_len;
    last_pkt = req_pkt;
  end

  typedef struct packed {
    logic [15:0]     tag;
    logic [4:0]      n;
    logic [0:15][7:0] b;
    logic            ok;
    logic [9:0]      len;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R2 legacy with two parameter bytes
    '{"R2", 5'd5,  '{0:8'hDC,1:8'h10,2:8'h02,3:8'hAA,4:8'hBB,default:8'h00}, 1'b1, 10'd5},
    // R2 legacy with no parameters
    '{"R2", 5'd3,  '{0:8'hDE,1:8'h22,2:8'h00,default:8'h00}, 1'b1, 10'd3},
    // R2 top legacy code
    '{"R2", 5'd6,  '{0:8'hFF,1:8'h01,2:8'h03,3:8'h11,4:8'h22,5:8'h33,default:8'h00}, 1'b1, 10'd6},
    // R3 packet with four body bytes
    '{"R3", 5'd12, '{0:8'h03,1:8'h5A,2:8'h34,3:8'h12,4:8'h00,5:8'h00,6:8'h04,7:8'h00,
                    8:8'hA1,9:8'hA2,10:8'hA3,11:8'hA4,default:8'h00}, 1'b1, 10'd12},
    // R3 packet with empty body
    '{"R3", 5'd8,  '{0:8'h03,1:8'h00,2:8'h01,default:8'h00}, 1'b1, 10'd8},
    // R5 unknown code
    '{"R5", 5'd4,  '{0:8'h05,1:8'h01,2:8'h00,3:8'h00,default:8'h00}, 1'b0, 10'd0},
    // R5 just below legacy base
    '{"R5", 5'd3,  '{0:8'hDB,1:8'h01,2:8'h00,default:8'h00}, 1'b0, 10'd0},
    // R5 just below packet code
    '{"R5", 5'd3,  '{0:8'h02,1:8'h01,2:8'h00,default:8'h00}, 1'b0, 10'd0},
    // R4 packet totalling 545 bytes
    '{"R4", 5'd10, '{0:8'h03,6:8'h19,7:8'h02,8:8'h55,9:8'h66,default:8'h00}, 1'b0, 10'd0},
    // R6 legacy cut short by chip select
    '{"R6", 5'd4,  '{0:8'hDC,1:8'h01,2:8'h05,3:8'h11,default:8'h00}, 1'b0, 10'd0}
  };

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b);
    logic [7:0] m;
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      m[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    if (m != 8'hFD) miso_err++;
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(20);
  endtask

  task automatic ack();
    req_ack = 1'b1;
    wait_clk(1);
    req_ack = 1'b0;
    wait_clk(2);
  endtask

  task automatic read_at(input int a, output logic [7:0] d);
    rd_addr = 10'(a);
    wait_clk(1);
    d = rd_data;
  endtask

  task automatic send_vec(input vec_t v);
    cs_open();
    for (int i = 0; i < int'(v.n); i++) xfer(v.b[i]);
    cs_close();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v0;
    wait_clk(5);
    // R1 reset state
    chk("R1", "req_valid in reset", req_valid, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1", "req_valid idle", req_valid, 0);
    chk("R1", "miso idle", miso, 1);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int k = 0; k < NV; k++) begin
      v0 = vcnt;
      miso_err = 0;
      send_vec(VEC[k]);
      chk(string'(VEC[k].tag), "strobe count", vcnt - v0, VEC[k].ok ? 1 : 0);
      chk("R10", "miso stall bytes", miso_err, 0);
      if (VEC[k].ok) begin
        chk(string'(VEC[k].tag), "req_len", last_len, VEC[k].len);
        chk(string'(VEC[k].tag), "req_pkt", last_pkt, VEC[k].b[0] == 8'h03);
        for (int i = 0; i < int'(VEC[k].n); i++) begin
          read_at(i, d);
          chk(string'(VEC[k].tag), "buffer byte", d, VEC[k].b[i]);
        end
        ack();
      end
    end

    // R8: clocking with chip select high, then a clean request
    for (int i = 0; i < 5; i++) begin
      mosi = i[0];
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    v0 = vcnt;
    cs_open(); xfer(8'hDC); xfer(8'h01); xfer(8'h00); cs_close();
    chk("R8", "strobe after idle clocks", vcnt - v0, 1);
    chk("R8", "length after idle clocks", last_len, 3);
    read_at(1, d);
    chk("R8", "byte alignment", d, 8'h01);
    ack();

    // R9: hold and freeze until acknowledge
    v0 = vcnt;
    cs_open(); xfer(8'hDC); xfer(8'h00); xfer(8'h01); xfer(8'h77); cs_close();
    chk("R9", "first strobe", vcnt - v0, 1);
    cs_open(); xfer(8'hDD); xfer(8'h00); xfer(8'h00); cs_close();
    chk("R9", "no strobe while held", vcnt - v0, 1);
    chk("R9", "length frozen", req_len, 4);
    read_at(0, d);
    chk("R9", "byte 0 frozen", d, 8'hDC);
    read_at(3, d);
    chk("R9", "byte 3 frozen", d, 8'h77);
    ack();
    wait_clk(10);
    chk("R9", "no strobe after ack", vcnt - v0, 1);

    // R7: phase budget expires, later bytes ignored until new fall
    v0 = vcnt;
    cs_open(); xfer(8'hDC); xfer(8'h00); xfer(8'h05); xfer(8'h01);
    wait_clk(TO_CYC + 200);
    xfer(8'h02); xfer(8'h03); xfer(8'h04); xfer(8'h05);
    cs_close();
    chk("R7", "no strobe after timeout", vcnt - v0, 0);
    cs_open(); xfer(8'hDC); xfer(8'h02); xfer(8'h00); cs_close();
    chk("R7", "recovers after timeout", vcnt - v0, 1);
    ack();

    // R4: exactly 544 bytes is accepted
    v0 = vcnt;
    cs_open();
    for (int i = 0; i < 544; i++) begin
      if (i == 0)      xfer(8'h03);
      else if (i == 6) xfer(8'h18);
      else if (i == 7) xfer(8'h02);
      else if (i < 8)  xfer(8'h00);
      else             xfer(8'(i) ^ 8'h5A);
    end
    cs_close();
    chk("R4", "strobe at 544", vcnt - v0, 1);
    chk("R4", "length 544", last_len, 544);
    read_at(543, d);
    chk("R4", "last byte", d, 8'(543) ^ 8'h5A);
    ack();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule